// File: doc/BRIEF.md
# Rewindable Packet FIFO

A single-clock first-in first-out buffer of 9-bit words whose read side can be wound back to a saved position. The consumer records its current read position with a mark strobe, reads a packet, and if the packet must be sent again, a retransmit strobe puts the read position back on the recorded word. This can be repeated any number of times, and the mark may sit on any word in the buffer.

While a mark is held, the word count used to declare the buffer full is taken from the older of the mark and the read position. The producer therefore cannot overwrite a packet that may still be resent. Raw empty, full and read-side occupancy are exported for a separate flag unit.

Both strobes and all data ports are sampled on the rising clock edge. Read data comes from a register and appears one cycle after a read is accepted, qualified by a valid bit. A synchronous clear input returns the block to the empty state. The asynchronous active-low reset is released on the clock inside the block.

Top module: `rewind_fifo`

## Requirements
- R1: After reset, or one cycle after a cycle with the clear input high, `empty_o` is 1, `full_o` is 0, `level_o` is 0 and `rd_valid_o` is 0. Clear overrides every other strobe in its cycle.
- R2: A write with `full_o` low stores `wr_data_i` and raises `level_o` by one in the next cycle. A write with `full_o` high is dropped and the word never appears at the output.
- R3: A read with `empty_o` low is accepted. Words come out in the order they were written, on `rd_data_o` with `rd_valid_o` high, in the cycle after the read.
- R4: A read with `empty_o` high is refused. In the next cycle `rd_valid_o` is 0 and `level_o` is unchanged.
- R5: `full_o` is 1 when `level_o` equals DEPTH. A write attempted in that state leaves `level_o` at DEPTH.
- R6: A mark strobe saves the read position. A later retransmit strobe restores it, so the following reads return the words starting from the marked one. Retransmit may be repeated any number of times.
- R7: Once a mark has been taken and until the next clear, `full_o` is also 1 when the number of words written since the mark position reaches DEPTH. This holds even if those words have been read, so marked data is never overwritten.
- R8: When a retransmit takes effect in the same cycle as a read, the read is ignored: `rd_valid_o` is 0 in the next cycle.
- R9: When mark and retransmit arrive together, the read position moves to the previously saved mark. The new mark is the read position from before that cycle.
- R10: A retransmit strobe with no mark taken since the last clear or reset has no effect, and a read in the same cycle proceeds.
- R11: In a cycle after which no read was accepted, `rd_valid_o` is 0 and `rd_data_o` holds its previous value.
- R12: `level_o` equals words written minus the read position. After a retransmit it equals words written minus the mark position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear to the empty state |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | WORD_W | Write word |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | WORD_W | Read word, registered |
| rd_valid_o | output | 1 | High in the cycle after an accepted read |
| mark_i | input | 1 | Save the current read position |
| rewind_i | input | 1 | Restore the read position from the saved mark |
| empty_o | output | 1 | No unread word |
| full_o | output | 1 | Writes refused |
| level_o | output | AW+1 | Unread word count |

## Verification
Every result is due exactly one clock after the edge that takes the stimulus. The pointers are the only state on the path to `empty_o`, `full_o` and `level_o`, and the read word register is the only state on the path to `rd_data_o` and `rd_valid_o`. The bench drives each stimulus on a falling edge and lets one rising edge take it. It then samples at the next falling edge, so each check reads the value due from that single edge. The same one-cycle rule is used by the checker properties, which relate the strobes in one cycle to the pointers and outputs in the next.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  // Per-cycle decisions taken by the control unit.
  typedef struct packed {
    logic clr;    // synchronous clear
    logic wr_ok;  // write accepted
    logic rd_ok;  // read accepted
    logic rw_ok;  // rewind takes effect
    logic mk_ok;  // mark captured
  } rwf_ctl_t;
endpackage

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
#(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          mark_i,
  input  logic          rewind_i,
  input  logic          empty_i,
  input  logic          full_i,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] mptr_o,
  output logic          mark_act_o,
  output rwf_ctl_t      ctl_o
);
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [PW-1:0] mptr_q, mptr_d;
  logic          mact_q, mact_d;
  rwf_ctl_t      ctl;

  // Decisions: clear beats all; an effective rewind beats a read.
  always_comb begin
    ctl.clr   = clear_i;
    ctl.rw_ok = !clear_i && rewind_i && mact_q;
    ctl.rd_ok = !clear_i && rd_en_i && !empty_i && !ctl.rw_ok;
    ctl.wr_ok = !clear_i && wr_en_i && !full_i;
    ctl.mk_ok = !clear_i && mark_i;
  end

  // Next state of the pointers.
  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    mptr_d = mptr_q;
    mact_d = mact_q;
    if (ctl.clr) begin
      wptr_d = '0;
      rptr_d = '0;
      mptr_d = '0;
      mact_d = 1'b0;
    end else begin
      if (ctl.wr_ok) wptr_d = wptr_q + PW'(1);
      if (ctl.rw_ok)      rptr_d = mptr_q;
      else if (ctl.rd_ok) rptr_d = rptr_q + PW'(1);
      if (ctl.mk_ok) begin
        mptr_d = rptr_q;  // value from before any rewind this cycle
        mact_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      mptr_q <= '0;
      mact_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      mptr_q <= mptr_d;
      mact_q <= mact_d;
    end
  end

  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;
  assign mptr_o     = mptr_q;
  assign mark_act_o = mact_q;
  assign ctl_o      = ctl;
endmodule

// File: rtl/rwf_flags.sv
module rwf_flags #(
  parameter int DEPTH = 1024,
  parameter int PW    = 11
) (
  input  logic [PW-1:0] wptr_i,
  input  logic [PW-1:0] rptr_i,
  input  logic [PW-1:0] mptr_i,
  input  logic          mark_act_i,
  output logic [PW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [PW-1:0] since_mark;

  always_comb begin
    level_o    = wptr_i - rptr_i;
    since_mark = wptr_i - mptr_i;
    empty_o    = (level_o == '0);
    // Full on either span: unread words, or words held since the mark.
    full_o     = (level_o == CAP) || (mark_act_i && (since_mark == CAP));
  end
endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 1024,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_ok_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;

  always_ff @(posedge clk) begin
    if (wr_ok_i) mem[waddr_i] <= wdata_i;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_ok_i) rdata_d = mem[raddr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd_ok_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rwf_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              mark_i,
  input  logic              rewind_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [PW-1:0]     level_o
);
  // Reset asserts at once, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PW-1:0] wptr, rptr, mptr;
  logic          mark_act;
  logic          empty, full;
  rwf_ctl_t      ctl;

  rwf_ctrl #(.PW(PW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (clear_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .mark_i     (mark_i),
    .rewind_i   (rewind_i),
    .empty_i    (empty),
    .full_i     (full),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .mptr_o     (mptr),
    .mark_act_o (mark_act),
    .ctl_o      (ctl)
  );

  rwf_flags #(.DEPTH(DEPTH), .PW(PW)) u_flags (
    .wptr_i     (wptr),
    .rptr_i     (rptr),
    .mptr_i     (mptr),
    .mark_act_i (mark_act),
    .level_o    (level_o),
    .empty_o    (empty),
    .full_o     (full)
  );

  rwf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_ok_i  (ctl.wr_ok),
    .waddr_i  (wptr[AW-1:0]),
    .wdata_i  (wr_data_i),
    .rd_ok_i  (ctl.rd_ok),
    .raddr_i  (rptr[AW-1:0]),
    .rdata_o  (rd_data_o),
    .rvalid_o (rd_valid_o)
  );

  assign empty_o = empty;
  assign full_o  = full;
endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 1024,
  parameter int PW     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              mark_i,
  input logic              rewind_i,
  input logic              empty_o,
  input logic              full_o,
  input logic [PW-1:0]     level_o,
  input logic              rd_valid_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [PW-1:0]     rptr,
  input logic [PW-1:0]     mptr,
  input logic              mark_act
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (empty_o && !full_o && level_o == '0 && !rd_valid_o));

  p_refused_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rd_valid_o) |-> $past(rd_en_i && !empty_o));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= PW'(DEPTH));

  p_rewind_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_i && mark_act && !clear_i) |=> rptr == $past(mptr));

  p_guard_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_act && (level_o + (rptr - mptr)) == PW'(DEPTH) && !(rptr - mptr > PW'(DEPTH))) |-> full_o);

  p_rewind_drops_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_i && mark_act && !clear_i) |=> !rd_valid_o);

  p_mark_grabs_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_i && !clear_i) |=> (mptr == $past(rptr) && mark_act));

  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !rd_valid_o) |-> $stable(rd_data_o));
endmodule

bind rewind_fifo rewind_fifo_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .clear_i    (clear_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .mark_i     (mark_i),
  .rewind_i   (rewind_i),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .level_o    (level_o),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .rptr       (rptr),
  .mptr       (mptr),
  .mark_act   (mark_act)
);

// File: tb/test_rewind_fifo.sv
module test_rewind_fifo;
  localparam int W  = 9;
  localparam int D  = 16;
  localparam int PW = 5;

  logic          clk;
  logic          rst_n;
  logic          clear_i, wr_en_i, rd_en_i, mark_i, rewind_i;
  logic [W-1:0]  wr_data_i;
  logic [W-1:0]  rd_data_o;
  logic          rd_valid_o, empty_o, full_o;
  logic [PW-1:0] level_o;

  int n_chk;
  int n_bad;

  rewind_fifo #(.WORD_W(W), .DEPTH(D)) i_rewind_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .mark_i     (mark_i),
    .rewind_i   (rewind_i),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .level_o    (level_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int cyc;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: drive on the falling edge, one rising edge takes it,
  // sampling happens at the following falling edge.
  task automatic op(input bit w, input logic [W-1:0] d, input bit r,
                    input bit m, input bit t, input bit c);
    wr_en_i = w; wr_data_i = d; rd_en_i = r;
    mark_i = m; rewind_i = t; clear_i = c;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 0; rd_en_i = 0; mark_i = 0; rewind_i = 0; clear_i = 0;
  endtask

  task automatic push(input logic [W-1:0] d); op(1, d, 0, 0, 0, 0); endtask
  task automatic idle();                      op(0, '0, 0, 0, 0, 0); endtask
  task automatic do_clear();                  op(0, '0, 0, 0, 0, 1); endtask
  task automatic do_mark();                   op(0, '0, 0, 1, 0, 0); endtask
  task automatic do_rewind();                 op(0, '0, 0, 0, 1, 0); endtask

  task automatic pop_exp(input logic [W-1:0] e, input string req);
    op(0, '0, 1, 0, 0, 0);
    chk(rd_valid_o == 1'b1, req, "rd_valid", rd_valid_o, 1);
    chk(rd_data_o == e, req, "rd_data", rd_data_o, e);
  endtask

  task automatic t_reset();
    chk(empty_o == 1'b1, "R1", "empty after reset", empty_o, 1);
    chk(full_o == 1'b0, "R1", "full after reset", full_o, 0);
    chk(level_o == '0, "R1", "level after reset", level_o, 0);
    chk(rd_valid_o == 1'b0, "R1", "valid after reset", rd_valid_o, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(W'(9'h0A0 + i));
    chk(level_o == PW'(5), "R2", "level after 5 writes", level_o, 5);
    chk(level_o == PW'(5), "R12", "level equals written minus read", level_o, 5);
    for (int i = 0; i < 5; i++) pop_exp(W'(9'h0A0 + i), "R3");
    idle();
    chk(rd_valid_o == 1'b0, "R11", "valid on idle", rd_valid_o, 0);
    chk(rd_data_o == 9'h0A4, "R11", "data held on idle", rd_data_o, 9'h0A4);
    op(0, '0, 1, 0, 0, 0);
    chk(rd_valid_o == 1'b0, "R4", "read on empty refused", rd_valid_o, 0);
    chk(level_o == '0, "R4", "level after refused read", level_o, 0);
  endtask

  task automatic t_full();
    push(9'h055);
    op(1, 9'h066, 0, 0, 0, 1);  // clear beats the write
    chk(empty_o == 1'b1 && level_o == '0, "R1", "clear empties", level_o, 0);
    for (int i = 0; i < D; i++) push(W'(9'h100 + i));
    chk(full_o == 1'b1, "R5", "full at DEPTH", full_o, 1);
    push(9'h1AB);
    chk(level_o == PW'(D), "R5", "level after write on full", level_o, D);
    for (int i = 0; i < D; i++) pop_exp(W'(9'h100 + i), "R2");
    op(0, '0, 1, 0, 0, 0);
    chk(rd_valid_o == 1'b0, "R2", "dropped word never appears", rd_valid_o, 0);
  endtask

  task automatic t_mark();
    do_clear();
    for (int i = 0; i < 6; i++) push(W'(9'h0B0 + i));
    pop_exp(9'h0B0, "R3");
    pop_exp(9'h0B1, "R3");
    do_mark();
    for (int i = 2; i < 5; i++) pop_exp(W'(9'h0B0 + i), "R6");
    do_rewind();
    chk(level_o == PW'(4), "R12", "level after rewind", level_o, 4);
    pop_exp(9'h0B2, "R6");
    pop_exp(9'h0B3, "R6");
    do_rewind();
    pop_exp(9'h0B2, "R6");
  endtask

  task automatic t_guard();
    do_clear();
    for (int i = 0; i < 10; i++) push(W'(9'h040 + i));
    do_mark();
    for (int i = 0; i < 10; i++) pop_exp(W'(9'h040 + i), "R7");
    chk(empty_o == 1'b1, "R7", "empty after draining", empty_o, 1);
    for (int i = 0; i < 5; i++) push(W'(9'h060 + i));
    chk(full_o == 1'b0, "R7", "not full one short", full_o, 0);
    push(9'h065);
    chk(full_o == 1'b1, "R7", "full measured from mark", full_o, 1);
    push(9'h1FF);
    chk(level_o == PW'(6), "R7", "write past mark blocked", level_o, 6);
    do_rewind();
    chk(level_o == PW'(D), "R12", "level from mark after rewind", level_o, D);
    pop_exp(9'h040, "R7");
  endtask

  task automatic t_rewind_read();
    do_clear();
    for (int i = 0; i < 4; i++) push(W'(9'h0C0 + i));
    pop_exp(9'h0C0, "R8");
    do_mark();
    pop_exp(9'h0C1, "R8");
    pop_exp(9'h0C2, "R8");
    op(0, '0, 1, 0, 1, 0);
    chk(rd_valid_o == 1'b0, "R8", "read dropped under rewind", rd_valid_o, 0);
    chk(level_o == PW'(3), "R8", "level after rewind", level_o, 3);
    pop_exp(9'h0C1, "R8");
  endtask

  task automatic t_mark_rewind();
    do_clear();
    for (int i = 0; i < 6; i++) push(W'(9'h0D0 + i));
    pop_exp(9'h0D0, "R9");
    do_mark();
    pop_exp(9'h0D1, "R9");
    pop_exp(9'h0D2, "R9");
    op(0, '0, 0, 1, 1, 0);
    pop_exp(9'h0D1, "R9");
    do_rewind();
    pop_exp(9'h0D3, "R9");
  endtask

  task automatic t_rewind_nomark();
    do_clear();
    for (int i = 0; i < 3; i++) push(W'(9'h0E0 + i));
    pop_exp(9'h0E0, "R10");
    op(0, '0, 1, 0, 1, 0);
    chk(rd_valid_o == 1'b1, "R10", "read proceeds", rd_valid_o, 1);
    chk(rd_data_o == 9'h0E1, "R10", "next word", rd_data_o, 9'h0E1);
    chk(level_o == PW'(1), "R10", "level", level_o, 1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    rst_n = 0; clear_i = 0; wr_en_i = 0; rd_en_i = 0;
    mark_i = 0; rewind_i = 0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_mark();
    t_guard();
    t_rewind_read();
    t_mark_rewind();
    t_rewind_nomark();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule